// File: doc/BRIEF.md
# Receive Descriptor Ring Writeback Engine

The engine steers an incoming frame, delivered one byte per cycle with a last-byte marker, into a ring of receive buffers. Each buffer is described by an entry in a small internal descriptor store. An entry holds an ownership bit, a first-buffer bit, a frame-end bit, an error bit, a buffer length and a message count. A set ownership bit means the engine may fill that buffer. The engine fills owned buffers in ring order. Every accepted byte is reported on a buffer-write strobe together with the descriptor index and the byte offset. When the engine is done with a buffer, it writes that descriptor back in a single update.

A host-side port acts as the driver. It reads any descriptor without side effects. While the host owns a descriptor, it can also rewrite that descriptor's length and ownership bit. One frame may span several buffers. The engine checks the ownership of the following descriptor at the moment a buffer fills. If that descriptor is not owned, the engine leaves it untouched, so any stale frame-end bit stays in place. It then discards the remainder of the frame and marks the last buffer it used with the error bit. A one-cycle frame-done pulse closes every frame that was written to the ring.

Top module: `rxr_wb_engine`

## Requirements
- R1: After reset, every descriptor reads all-zero (flags, length and count), and neither `buf_we` nor `frame_done` is high.
- R2: The engine writes only into descriptors whose ownership bit is 1. If a frame starts while the current descriptor is not owned, the whole frame is discarded: no descriptor changes, no byte strobe, no done pulse, and the ring position stays where it was.
- R3: In a writeback, the first-buffer bit is 1 for the buffer that took the frame's first byte and 0 for every later buffer of that frame.
- R4: A buffer that fills without holding the frame's last byte is written back with ownership 0, frame-end 0, error 0 and message count 0.
- R5: The buffer holding the last byte is written back with ownership 0 and a message count equal to the bytes placed in it. The frame-end bit is 1 and the error bit is 0. If `rx_bad` is set with the last byte, the error bit is 1 and the frame-end bit is 0 instead.
- R6: A frame that ends early leaves all later descriptors unwritten, and the next frame starts at the descriptor after the last one used. The ring index wraps from NDESC-1 to 0, including in the middle of a frame.
- R7: If a buffer fills, more bytes follow, and the next descriptor is not owned, the engine does three things. It writes the full buffer back with ownership 0, error 1, frame-end 0 and a count of its bytes. It leaves the next descriptor completely unchanged. It drops the rest of the frame through its last byte. The next frame starts at that unchanged descriptor.
- R8: A host write changes a descriptor's length and ownership only while that descriptor's ownership bit is 0. A host write to an engine-owned descriptor has no effect. The engine latches a buffer's length when it places the first byte in that buffer.
- R9: `frame_done` is high for exactly one cycle. That cycle is the one in which the final writeback of a frame (frame-end or error) first reads back on the host port.
- R10: Each accepted byte appears on `buf_we`/`buf_idx`/`buf_off`/`buf_data` in the cycle after it is presented. Offsets within a buffer count up from 0.
- R11: A host write that gives ownership of the next descriptor in the same cycle as the engine's look-ahead is not seen by that look-ahead. The engine takes the R7 path, but the host write is still applied, and the next frame uses that descriptor.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| rx_valid | input | 1 | Byte present this cycle |
| rx_data | input | DATA_W | Byte value |
| rx_last | input | 1 | Byte is the last of its frame |
| rx_bad | input | 1 | Frame ended with an error (sampled with the last byte) |
| buf_we | output | 1 | Byte written to a buffer |
| buf_idx | output | $clog2(NDESC) | Descriptor index of the buffer written |
| buf_off | output | LEN_W | Offset within that buffer |
| buf_data | output | DATA_W | Byte written |
| frame_done | output | 1 | One-cycle pulse after a frame's closing writeback |
| h_rd_idx | input | $clog2(NDESC) | Host read index |
| h_rd_own | output | 1 | Ownership bit of the read descriptor |
| h_rd_stp | output | 1 | First-buffer bit |
| h_rd_enp | output | 1 | Frame-end bit |
| h_rd_err | output | 1 | Error bit |
| h_rd_len | output | LEN_W | Buffer length |
| h_rd_mcnt | output | LEN_W | Message count |
| h_wr_en | input | 1 | Host write request |
| h_wr_idx | input | $clog2(NDESC) | Host write index |
| h_wr_len | input | LEN_W | New buffer length |
| h_wr_own | input | 1 | New ownership bit |

## Verification
Two events can land in the same cycle. One is the engine's look-ahead on the next descriptor's ownership bit, taken as the current buffer fills mid-frame. The other is a host write that hands that very descriptor to the engine. The bench provokes the collision by issuing the host write on exactly the byte that fills a two-byte buffer. It then judges three things: the full buffer is closed with the error bit, the given descriptor keeps its stale frame-end bit but does get the new ownership, and the following frame lands in that descriptor. A behavioural ring model steps on every edge and checks this ordering, along with every byte strobe and done pulse.

// File: rtl/rxr_pkg.sv
package rxr_pkg;
  typedef struct packed {
    logic own;
    logic stp;
    logic enp;
    logic err;
  } rxr_flags_t;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_FILL = 2'd1,
    ST_DROP = 2'd2
  } rxr_state_t;
endpackage

// File: rtl/rxr_rst_sync.sv
module rxr_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_sync
);
  logic [1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= 2'b00;
    else        sync_q <= {sync_q[0], 1'b1};
  end

  assign rst_n_sync = sync_q[1];
endmodule

// File: rtl/rxr_desc_mem.sv
module rxr_desc_mem
  import rxr_pkg::*;
#(
  parameter int NDESC = 8,
  parameter int LEN_W = 8,
  localparam int IDX_W = $clog2(NDESC)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [IDX_W-1:0] rd_idx,
  output rxr_flags_t       rd_flags,
  output logic [LEN_W-1:0] rd_len,
  output logic [LEN_W-1:0] rd_mcnt,
  input  logic [IDX_W-1:0] cur_idx,
  output logic             cur_own,
  output logic [LEN_W-1:0] cur_len,
  input  logic [IDX_W-1:0] nxt_idx,
  output logic             nxt_own,
  input  logic             eng_we,
  input  logic [IDX_W-1:0] eng_widx,
  input  rxr_flags_t       eng_wflags,
  input  logic [LEN_W-1:0] eng_wmcnt,
  input  logic             host_we,
  input  logic [IDX_W-1:0] host_widx,
  input  logic [LEN_W-1:0] host_len,
  input  logic             host_own
);
  rxr_flags_t       flags_q [NDESC];
  rxr_flags_t       flags_d [NDESC];
  logic [LEN_W-1:0] len_q   [NDESC];
  logic [LEN_W-1:0] len_d   [NDESC];
  logic [LEN_W-1:0] mcnt_q  [NDESC];
  logic [LEN_W-1:0] mcnt_d  [NDESC];

  always_comb begin
    for (int i = 0; i < NDESC; i++) begin
      flags_d[i] = flags_q[i];
      len_d[i]   = len_q[i];
      mcnt_d[i]  = mcnt_q[i];
      if (eng_we && eng_widx == IDX_W'(i)) begin
        flags_d[i] = eng_wflags;
        mcnt_d[i]  = eng_wmcnt;
      end else if (host_we && host_widx == IDX_W'(i) && !flags_q[i].own) begin
        flags_d[i].own = host_own;
        len_d[i]       = host_len;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < NDESC; i++) begin
        flags_q[i] <= '0;
        len_q[i]   <= '0;
        mcnt_q[i]  <= '0;
      end
    end else begin
      for (int i = 0; i < NDESC; i++) begin
        flags_q[i] <= flags_d[i];
        len_q[i]   <= len_d[i];
        mcnt_q[i]  <= mcnt_d[i];
      end
    end
  end

  assign rd_flags = flags_q[rd_idx];
  assign rd_len   = len_q[rd_idx];
  assign rd_mcnt  = mcnt_q[rd_idx];
  assign cur_own  = flags_q[cur_idx].own;
  assign cur_len  = len_q[cur_idx];
  assign nxt_own  = flags_q[nxt_idx].own;

  // R2: the engine only writes back a descriptor it owns
  assert_wb_owned_R2: assert property (@(posedge clk) disable iff (!rst_n)
    eng_we |-> flags_q[eng_widx].own);

  // R4 / R5: ownership is released by every writeback
  assert_wb_releases_R4: assert property (@(posedge clk) disable iff (!rst_n)
    eng_we |=> !flags_q[$past(eng_widx)].own);

  generate
    for (genvar g = 0; g < NDESC; g++) begin : g_host_guard
      // R8: a host write to an engine-owned entry leaves its length alone
      assert_host_locked_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (host_we && host_widx == IDX_W'(g) && flags_q[g].own)
          |=> len_q[g] == $past(len_q[g]));
    end
  endgenerate
endmodule

// File: rtl/rxr_fill_ctl.sv
module rxr_fill_ctl
  import rxr_pkg::*;
#(
  parameter int NDESC  = 8,
  parameter int LEN_W  = 8,
  parameter int DATA_W = 8,
  localparam int IDX_W = $clog2(NDESC)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rx_valid,
  input  logic [DATA_W-1:0] rx_data,
  input  logic              rx_last,
  input  logic              rx_bad,
  input  logic              cur_own,
  input  logic [LEN_W-1:0]  cur_len,
  input  logic              nxt_own,
  output logic [IDX_W-1:0]  cur_idx,
  output logic [IDX_W-1:0]  nxt_idx,
  output logic              eng_we,
  output rxr_flags_t        eng_wflags,
  output logic [LEN_W-1:0]  eng_wmcnt,
  output logic              buf_we,
  output logic [IDX_W-1:0]  buf_idx,
  output logic [LEN_W-1:0]  buf_off,
  output logic [DATA_W-1:0] buf_data,
  output logic              frame_done
);
  rxr_state_t        st_q, st_d;
  logic [IDX_W-1:0]  idx_q, idx_d;
  logic [LEN_W-1:0]  pos_q, pos_d;
  logic [LEN_W-1:0]  clen_q, clen_d;
  logic              first_q, first_d;
  logic              bwe_q, bwe_d;
  logic [IDX_W-1:0]  bidx_q, bidx_d;
  logic [LEN_W-1:0]  boff_q, boff_d;
  logic [DATA_W-1:0] bdat_q, bdat_d;
  logic              done_q, done_d;

  logic             take, accept, full, stp_v;
  logic [LEN_W-1:0] use_len, off, cnt1;

  assign cur_idx = idx_q;
  assign nxt_idx = idx_q + 1'b1;

  always_comb begin
    take    = (st_q == ST_IDLE && cur_own) || (st_q == ST_FILL && pos_q == '0);
    accept  = rx_valid && (st_q == ST_FILL || (st_q == ST_IDLE && cur_own));
    use_len = take ? cur_len : clen_q;
    off     = take ? '0 : pos_q;
    cnt1    = off + 1'b1;
    full    = cnt1 >= use_len;
    stp_v   = (st_q == ST_IDLE) ? 1'b1 : first_q;

    st_d = st_q; idx_d = idx_q; pos_d = pos_q; clen_d = clen_q; first_d = first_q;
    bwe_d = 1'b0; bidx_d = bidx_q; boff_d = boff_q; bdat_d = bdat_q; done_d = 1'b0;
    eng_we = 1'b0; eng_wflags = '0; eng_wmcnt = '0;

    if (st_q == ST_DROP) begin
      if (rx_valid && rx_last) st_d = ST_IDLE;
    end else if (rx_valid && !accept) begin
      if (!rx_last) st_d = ST_DROP;
    end else if (accept) begin
      bwe_d  = 1'b1;
      bidx_d = idx_q;
      boff_d = off;
      bdat_d = rx_data;
      if (take) clen_d = cur_len;
      if (rx_last) begin
        eng_we     = 1'b1;
        eng_wflags = '{own: 1'b0, stp: stp_v, enp: !rx_bad, err: rx_bad};
        eng_wmcnt  = cnt1;
        idx_d      = idx_q + 1'b1;
        st_d       = ST_IDLE;
        done_d     = 1'b1;
      end else if (full) begin
        eng_we = 1'b1;
        idx_d  = idx_q + 1'b1;
        if (nxt_own) begin
          eng_wflags = '{own: 1'b0, stp: stp_v, enp: 1'b0, err: 1'b0};
          st_d       = ST_FILL;
          pos_d      = '0;
          first_d    = 1'b0;
        end else begin
          eng_wflags = '{own: 1'b0, stp: stp_v, enp: 1'b0, err: 1'b1};
          eng_wmcnt  = cnt1;
          st_d       = ST_DROP;
          done_d     = 1'b1;
        end
      end else begin
        st_d    = ST_FILL;
        pos_d   = cnt1;
        first_d = stp_v;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q <= ST_IDLE; idx_q <= '0; pos_q <= '0; clen_q <= '0; first_q <= 1'b0;
      bwe_q <= 1'b0; bidx_q <= '0; boff_q <= '0; bdat_q <= '0; done_q <= 1'b0;
    end else begin
      st_q <= st_d; idx_q <= idx_d; pos_q <= pos_d; clen_q <= clen_d; first_q <= first_d;
      bwe_q <= bwe_d; done_q <= done_d;
      if (bwe_d) begin
        bidx_q <= bidx_d; boff_q <= boff_d; bdat_q <= bdat_d;
      end
    end
  end

  assign buf_we     = bwe_q;
  assign buf_idx    = bidx_q;
  assign buf_off    = boff_q;
  assign buf_data   = bdat_q;
  assign frame_done = done_q;

  // R10: a reported offset always lies inside the latched buffer length
  assert_off_in_buf_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (bwe_q && clen_q != '0) |-> boff_q < clen_q);

  // R7: while a frame is being discarded nothing is strobed out
  assert_drop_quiet_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ST_DROP && $past(st_q == ST_DROP)) |-> !bwe_q);

  // R9: a done pulse is always preceded by a writeback
  assert_done_after_wb_R9: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(done_q) |-> $past(eng_we));
endmodule

// File: rtl/rxr_wb_engine.sv
module rxr_wb_engine
  import rxr_pkg::*;
#(
  parameter int NDESC  = 8,
  parameter int LEN_W  = 8,
  parameter int DATA_W = 8
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     rx_valid,
  input  logic [DATA_W-1:0]        rx_data,
  input  logic                     rx_last,
  input  logic                     rx_bad,
  output logic                     buf_we,
  output logic [$clog2(NDESC)-1:0] buf_idx,
  output logic [LEN_W-1:0]         buf_off,
  output logic [DATA_W-1:0]        buf_data,
  output logic                     frame_done,
  input  logic [$clog2(NDESC)-1:0] h_rd_idx,
  output logic                     h_rd_own,
  output logic                     h_rd_stp,
  output logic                     h_rd_enp,
  output logic                     h_rd_err,
  output logic [LEN_W-1:0]         h_rd_len,
  output logic [LEN_W-1:0]         h_rd_mcnt,
  input  logic                     h_wr_en,
  input  logic [$clog2(NDESC)-1:0] h_wr_idx,
  input  logic [LEN_W-1:0]         h_wr_len,
  input  logic                     h_wr_own
);
  localparam int IDX_W = $clog2(NDESC);

  logic             rst_n_s;
  logic [IDX_W-1:0] cur_idx, nxt_idx;
  logic             cur_own, nxt_own, eng_we;
  logic [LEN_W-1:0] cur_len, eng_wmcnt;
  rxr_flags_t       eng_wflags, rd_flags;

  rxr_rst_sync u_rst (.clk(clk), .rst_n(rst_n), .rst_n_sync(rst_n_s));

  rxr_desc_mem #(.NDESC(NDESC), .LEN_W(LEN_W)) u_mem (
    .clk(clk), .rst_n(rst_n_s),
    .rd_idx(h_rd_idx), .rd_flags(rd_flags), .rd_len(h_rd_len), .rd_mcnt(h_rd_mcnt),
    .cur_idx(cur_idx), .cur_own(cur_own), .cur_len(cur_len),
    .nxt_idx(nxt_idx), .nxt_own(nxt_own),
    .eng_we(eng_we), .eng_widx(cur_idx), .eng_wflags(eng_wflags), .eng_wmcnt(eng_wmcnt),
    .host_we(h_wr_en), .host_widx(h_wr_idx), .host_len(h_wr_len), .host_own(h_wr_own)
  );

  rxr_fill_ctl #(.NDESC(NDESC), .LEN_W(LEN_W), .DATA_W(DATA_W)) u_ctl (
    .clk(clk), .rst_n(rst_n_s),
    .rx_valid(rx_valid), .rx_data(rx_data), .rx_last(rx_last), .rx_bad(rx_bad),
    .cur_own(cur_own), .cur_len(cur_len), .nxt_own(nxt_own),
    .cur_idx(cur_idx), .nxt_idx(nxt_idx),
    .eng_we(eng_we), .eng_wflags(eng_wflags), .eng_wmcnt(eng_wmcnt),
    .buf_we(buf_we), .buf_idx(buf_idx), .buf_off(buf_off), .buf_data(buf_data),
    .frame_done(frame_done)
  );

  assign h_rd_own = rd_flags.own;
  assign h_rd_stp = rd_flags.stp;
  assign h_rd_enp = rd_flags.enp;
  assign h_rd_err = rd_flags.err;
endmodule

// File: tb/sim_rxr_wb_engine.sv
module sim_rxr_wb_engine;
  localparam int N  = 8;
  localparam int LW = 8;
  localparam int IW = $clog2(N);

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic rx_valid = 1'b0, rx_last = 1'b0, rx_bad = 1'b0;
  logic [7:0] rx_data = '0;
  logic buf_we, frame_done;
  logic [IW-1:0] buf_idx;
  logic [LW-1:0] buf_off;
  logic [7:0] buf_data;
  logic [IW-1:0] h_rd_idx = '0, h_wr_idx = '0;
  logic h_rd_own, h_rd_stp, h_rd_enp, h_rd_err;
  logic [LW-1:0] h_rd_len, h_rd_mcnt, h_wr_len = '0;
  logic h_wr_en = 1'b0, h_wr_own = 1'b0;

  always #10 clk = ~clk;

  rxr_wb_engine #(.NDESC(N), .LEN_W(LW), .DATA_W(8)) u0 (
    .clk(clk), .rst_n(rst_n), .rx_valid(rx_valid), .rx_data(rx_data), .rx_last(rx_last),
    .rx_bad(rx_bad), .buf_we(buf_we), .buf_idx(buf_idx), .buf_off(buf_off),
    .buf_data(buf_data), .frame_done(frame_done), .h_rd_idx(h_rd_idx), .h_rd_own(h_rd_own),
    .h_rd_stp(h_rd_stp), .h_rd_enp(h_rd_enp), .h_rd_err(h_rd_err), .h_rd_len(h_rd_len),
    .h_rd_mcnt(h_rd_mcnt), .h_wr_en(h_wr_en), .h_wr_idx(h_wr_idx), .h_wr_len(h_wr_len),
    .h_wr_own(h_wr_own));

  int n_chk = 0, n_bad = 0, done_cnt = 0;
  string cur_req = "R1";

  task automatic chk(input string tag, input string what, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, exp);
    end
  endtask

  // behavioural ring model
  int m_own[N], m_stp[N], m_enp[N], m_err[N], m_len[N], m_cnt[N];
  int m_idx, m_pos, m_clen;
  bit m_busy, m_first, m_drop, e_we, e_done;
  int e_idx, e_off, e_dat;

  always @(posedge clk) begin
    if (!rst_n) begin
      for (int k = 0; k < N; k++) begin
        m_own[k] = 0; m_stp[k] = 0; m_enp[k] = 0; m_err[k] = 0; m_len[k] = 0; m_cnt[k] = 0;
      end
      m_idx = 0; m_pos = 0; m_clen = 0; m_busy = 0; m_first = 0; m_drop = 0;
      e_we = 0; e_done = 0; e_idx = 0; e_off = 0; e_dat = 0;
    end else begin
      int host_old_own, nx, off;
      host_old_own = m_own[h_wr_idx];
      e_we = 0; e_done = 0;
      if (rx_valid) begin
        if (m_drop) begin
          if (rx_last) m_drop = 0;
        end else if (!m_busy && m_own[m_idx] == 0) begin
          if (!rx_last) m_drop = 1;
        end else begin
          if (!m_busy) begin m_busy = 1; m_first = 1; m_pos = 0; end
          if (m_pos == 0) m_clen = m_len[m_idx];
          off = m_pos;
          e_we = 1; e_idx = m_idx; e_off = off; e_dat = rx_data;
          if (rx_last) begin
            m_own[m_idx] = 0; m_stp[m_idx] = m_first; m_enp[m_idx] = !rx_bad;
            m_err[m_idx] = rx_bad; m_cnt[m_idx] = off + 1;
            m_idx = (m_idx + 1) % N; m_busy = 0; e_done = 1;
          end else if (off + 1 >= m_clen) begin
            nx = (m_idx + 1) % N;
            m_own[m_idx] = 0; m_stp[m_idx] = m_first; m_enp[m_idx] = 0;
            if (m_own[nx] != 0) begin
              m_err[m_idx] = 0; m_cnt[m_idx] = 0; m_first = 0; m_pos = 0;
            end else begin
              m_err[m_idx] = 1; m_cnt[m_idx] = off + 1; m_busy = 0; m_drop = 1; e_done = 1;
            end
            m_idx = nx;
          end else m_pos = off + 1;
        end
      end
      if (h_wr_en && host_old_own == 0) begin
        m_own[h_wr_idx] = h_wr_own; m_len[h_wr_idx] = h_wr_len;
      end
    end
  end

  // per-cycle comparison of the strobe outputs
  always @(negedge clk) if (rst_n) begin
    if (frame_done) done_cnt++;
    chk("R10", "buf_we", buf_we, e_we);
    if (e_we) begin
      chk("R10", "buf_idx", buf_idx, e_idx);
      chk("R10", "buf_off", buf_off, e_off);
      chk("R10", "buf_data", buf_data, e_dat);
    end
    chk("R9", "frame_done", frame_done, e_done);
  end

  task automatic peek(input int k, input string tag, input int own, input int stp,
                      input int enp, input int err, input int mcnt);
    h_rd_idx = IW'(k); #1;
    chk(tag, $sformatf("d%0d.own", k), h_rd_own, own);
    chk(tag, $sformatf("d%0d.stp", k), h_rd_stp, stp);
    chk(tag, $sformatf("d%0d.enp", k), h_rd_enp, enp);
    chk(tag, $sformatf("d%0d.err", k), h_rd_err, err);
    chk(tag, $sformatf("d%0d.mcnt", k), h_rd_mcnt, mcnt);
  endtask

  task automatic peek_len(input int k, input string tag, input int len);
    h_rd_idx = IW'(k); #1;
    chk(tag, $sformatf("d%0d.len", k), h_rd_len, len);
  endtask

  task automatic sweep();
    for (int k = 0; k < N; k++) begin
      h_rd_idx = IW'(k); #1;
      chk(cur_req, $sformatf("model d%0d.own", k), h_rd_own, m_own[k]);
      chk(cur_req, $sformatf("model d%0d.stp", k), h_rd_stp, m_stp[k]);
      chk(cur_req, $sformatf("model d%0d.enp", k), h_rd_enp, m_enp[k]);
      chk(cur_req, $sformatf("model d%0d.err", k), h_rd_err, m_err[k]);
      chk(cur_req, $sformatf("model d%0d.len", k), h_rd_len, m_len[k]);
      chk(cur_req, $sformatf("model d%0d.mcnt", k), h_rd_mcnt, m_cnt[k]);
    end
  endtask

  task automatic host_wr(input int k, input int len, input bit own);
    h_wr_en = 1'b1; h_wr_idx = IW'(k); h_wr_len = LW'(len); h_wr_own = own;
    @(negedge clk);
    h_wr_en = 1'b0;
  endtask

  // sends a frame; optionally issues a host write alongside byte hw_at
  task automatic send(input int n, input bit bad, input int base, input int hw_at,
                      input int hidx, input int hlen);
    for (int i = 0; i < n; i++) begin
      rx_valid = 1'b1; rx_data = 8'(base + i);
      rx_last = (i == n - 1); rx_bad = bad && (i == n - 1);
      if (i == hw_at) begin
        h_wr_en = 1'b1; h_wr_idx = IW'(hidx); h_wr_len = LW'(hlen); h_wr_own = 1'b1;
      end
      @(negedge clk);
      h_wr_en = 1'b0;
    end
    rx_valid = 1'b0; rx_last = 1'b0; rx_bad = 1'b0;
    repeat (3) @(negedge clk);
  endtask

  task automatic finish_run();
    $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL R10 watchdog expired actual=1 expected=0");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    // R1: reset state
    cur_req = "R1";
    chk("R1", "buf_we", buf_we, 0);
    chk("R1", "frame_done", frame_done, 0);
    for (int k = 0; k < N; k++) begin
      peek(k, "R1", 0, 0, 0, 0, 0);
      peek_len(k, "R1", 0);
    end

    // R2: frame into an unowned ring is discarded
    cur_req = "R2"; done_cnt = 0;
    send(3, 0, 8'h01, -1, 0, 0);
    chk("R2", "done pulses", done_cnt, 0);
    peek(0, "R2", 0, 0, 0, 0, 0);
    sweep();

    // R3 R4 R5 R6: multi-buffer frame ending early
    cur_req = "R3";
    for (int k = 0; k < 4; k++) host_wr(k, 4, 1'b1);
    done_cnt = 0;
    send(10, 0, 8'h10, -1, 0, 0);
    peek(0, "R3", 0, 1, 0, 0, 0);
    peek(0, "R4", 0, 1, 0, 0, 0);
    peek(1, "R3", 0, 0, 0, 0, 0);
    peek(2, "R5", 0, 0, 1, 0, 2);
    peek(3, "R6", 1, 0, 0, 0, 0);
    chk("R9", "done pulses", done_cnt, 1);
    sweep();

    // R8: host write gated by ownership
    cur_req = "R8";
    host_wr(3, 9, 1'b1);
    peek_len(3, "R8", 4);
    host_wr(0, 6, 1'b0);
    peek_len(0, "R8", 6);
    sweep();

    // R5: frame ending with an error
    cur_req = "R5";
    send(3, 1, 8'h30, -1, 0, 0);
    peek(3, "R5", 0, 1, 0, 1, 3);
    sweep();

    // R7: look-ahead finds the next descriptor unowned
    cur_req = "R7"; done_cnt = 0;
    host_wr(4, 2, 1'b1);
    send(5, 0, 8'h40, -1, 0, 0);
    peek(4, "R7", 0, 1, 0, 1, 2);
    peek(5, "R7", 0, 0, 0, 0, 0);
    chk("R7", "done pulses", done_cnt, 1);
    sweep();

    // R6: ring wrap inside a frame
    cur_req = "R6";
    host_wr(5, 3, 1'b1); host_wr(6, 3, 1'b1); host_wr(7, 3, 1'b1); host_wr(0, 3, 1'b1);
    send(3, 0, 8'h50, -1, 0, 0);
    peek(5, "R6", 0, 1, 1, 0, 3);
    send(3, 0, 8'h60, -1, 0, 0);
    send(5, 0, 8'h70, -1, 0, 0);
    peek(7, "R6", 0, 1, 0, 0, 0);
    peek(0, "R6", 0, 0, 1, 0, 2);
    sweep();

    // R11: host gives the look-ahead descriptor in the same cycle
    cur_req = "R11"; done_cnt = 0;
    host_wr(1, 2, 1'b1);
    send(4, 0, 8'h80, 1, 2, 4);
    peek(1, "R11", 0, 1, 0, 1, 2);
    peek(2, "R7", 1, 0, 1, 0, 2);
    peek_len(2, "R11", 4);
    chk("R11", "done pulses", done_cnt, 1);
    send(2, 0, 8'h90, -1, 0, 0);
    peek(2, "R11", 0, 1, 1, 0, 2);
    sweep();

    repeat (2) @(negedge clk);
    finish_run();
  end
endmodule